// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked controller that links a simple synchronous request port to an external asynchronous static RAM of 131,072 bytes. The user side presents a request with valid/ready, a write flag, a 17-bit address and 8-bit write data. Read results come back as a one-cycle valid pulse with 8 bits of data. On the memory side the block drives active-low chip-select, output-enable and write-strobe pins and a 17-bit address. It also controls an 8-bit shared data bus through separate output, output-enable and input signals.

Every timing rule of the memory is a parameter in picoseconds, as is the clock period. Each wait count is the ceiling of the limit divided by the period, with a floor of one cycle. With the defaults (8 ns clock) a read holds the memory selected for 2 cycles and then releases it for 1 cycle. A write takes a setup cycle, 1 cycle of strobe low and a hold cycle. After reset the block stays unavailable for the 100 µs power-up interval, which is 12,500 cycles.

The state machine has seven states. PWRUP moves to IDLE when the power-up counter reaches zero. From IDLE, an accepted request goes to RD when the write flag is low, or to WSET when it is high. RD moves to RREL after its read wait count, and RREL returns to IDLE after the release count. WSET moves to WPULSE after one cycle. WPULSE moves to WHOLD after the strobe width count, and WHOLD returns to IDLE after one cycle.

Top module: `sram_ctl`

## Requirements
- R1: After reset release, `req_ready` stays low and `sram_ce_n`, `sram_oe_n` and `sram_we_n` stay high with `sram_dq_oe` low for PWRUP_CYC = ceil(T_PWRUP_PS/CLK_PS) clock edges. `req_ready` is first high after exactly that many edges (12,500 with the defaults).
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the following cycle and returns high only when the access and its release phase are over. That is RD_CYC+HZ_CYC edges after acceptance for a read, and 2+PWE_CYC edges for a write.
- R3: A read holds `sram_ce_n` and `sram_oe_n` low, `sram_we_n` high and `sram_addr` equal to the request address for RD_CYC cycles. RD_CYC is the largest of the cycle counts for the read cycle time, the address access time and the output-enable access time. `sram_dq_in` is captured at the end of the last of these cycles. `rd_valid` pulses high for one cycle, RD_CYC edges after acceptance.
- R4: After a read, chip select and output enable are high for HZ_CYC cycles before the block returns to idle. The controller does not drive the data bus during this time.
- R5: A write spends one setup cycle with chip select low, strobe high and data driven. It then holds `sram_we_n` low for PWE_CYC cycles, followed by one hold cycle with the strobe high and data still driven. After that `sram_dq_oe` is released.
- R6: `sram_oe_n` is high whenever `sram_we_n` is low or `sram_dq_oe` is high, so the controller and the memory never drive the data bus in the same cycle.
- R7: `sram_addr` and `sram_dq_out` equal the request address and data in every cycle in which `sram_dq_oe` is high.
- R8: A read returns the data of the last write to that address, including the lowest (0x00000) and highest (0x1FFFF) addresses. A location never written reads as 0x00 in the bench memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: read data valid |
| rd_data | output | 8 | Read data |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_addr | output | 17 | Memory address |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable of the data driver |
| sram_dq_in | input | 8 | Data returned by the memory |

## Verification
The assertions assume two things about the inputs. The request fields stay stable while `req_valid` is high. Reset is held for at least one edge. The bench meets both by driving requests only at the falling edge, and it drops `req_valid` in the cycle after the accepting edge. The bench memory model only returns valid data after chip select and output enable have been low at the same address for two falling edges. It keeps driving for one cycle after release. A short read wait or a missing release phase therefore shows up as bad data or a bus conflict. Random reads and writes draw from a small address pool, so that read-after-write hits are frequent. Directed accesses cover the two end addresses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_RD,
        ST_RREL,
        ST_WSET,
        ST_WPULSE,
        ST_WHOLD
    } ctl_state_t;

    // ceiling of limit / period, never below one cycle
    function automatic int unsigned wait_cycles(int unsigned lim_ps, int unsigned clk_ps);
        int unsigned c;
        c = (lim_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_ctl_down.sv
module sram_ctl_down #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [DW-1:0] din,
    output logic          valid,
    output logic [DW-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= cap;
            if (cap)
                data <= din;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_PS     = 8000,
    parameter int unsigned T_RC_PS    = 10000,
    parameter int unsigned T_AA_PS    = 10000,
    parameter int unsigned T_DOE_PS   = 5000,
    parameter int unsigned T_HZ_PS    = 5000,
    parameter int unsigned T_PWE_PS   = 7000,
    parameter int unsigned T_PWRUP_PS = 100_000_000,
    parameter int          AW         = 17,
    parameter int          DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_out,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_in
);

    localparam int unsigned RD_CYC    = max3(wait_cycles(T_RC_PS, CLK_PS),
                                             wait_cycles(T_AA_PS, CLK_PS),
                                             wait_cycles(T_DOE_PS, CLK_PS));
    localparam int unsigned HZ_CYC    = wait_cycles(T_HZ_PS, CLK_PS);
    localparam int unsigned PWE_CYC   = wait_cycles(T_PWE_PS, CLK_PS);
    localparam int unsigned PWRUP_CYC = wait_cycles(T_PWRUP_PS, CLK_PS);
    localparam int unsigned PH_MAX    = max3(RD_CYC, HZ_CYC, PWE_CYC);
    localparam int          PH_W      = $clog2(PH_MAX + 1);
    localparam int          PW_W      = $clog2(PWRUP_CYC + 1);

    ctl_state_t state, state_nxt;

    logic            ph_load;
    logic [PH_W-1:0] ph_load_val;
    logic            ph_zero;
    logic            pw_zero;
    logic            accept;
    logic            rd_cap;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;

    // power-up hold-off counter: counts down once from reset
    sram_ctl_down #(.W(PW_W), .RST_VAL(int'(PWRUP_CYC) - 1)) u_pwrup (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (1'b0),
        .load_val ({PW_W{1'b0}}),
        .zero     (pw_zero)
    );

    // per-phase wait-state counter, reloaded on every state change
    sram_ctl_down #(.W(PH_W), .RST_VAL(0)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_load_val),
        .zero     (ph_zero)
    );

    assign accept = req_valid && req_ready;
    assign rd_cap = (state == ST_RD) && ph_zero;

    sram_ctl_rdcap #(.DW(DW)) u_rdcap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (rd_cap),
        .din   (sram_dq_in),
        .valid (rd_valid),
        .data  (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_PWRUP;
        else
            state <= state_nxt;
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // next state and phase length
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_PWRUP:  if (pw_zero) state_nxt = ST_IDLE;
            ST_IDLE:   if (req_valid) state_nxt = req_we ? ST_WSET : ST_RD;
            ST_RD:     if (ph_zero) state_nxt = ST_RREL;
            ST_RREL:   if (ph_zero) state_nxt = ST_IDLE;
            ST_WSET:   if (ph_zero) state_nxt = ST_WPULSE;
            ST_WPULSE: if (ph_zero) state_nxt = ST_WHOLD;
            ST_WHOLD:  if (ph_zero) state_nxt = ST_IDLE;
            default:   state_nxt = ST_PWRUP;
        endcase

        ph_load     = (state_nxt != state);
        ph_load_val = '0;
        unique case (state_nxt)
            ST_RD:     ph_load_val = PH_W'(RD_CYC - 1);
            ST_RREL:   ph_load_val = PH_W'(HZ_CYC - 1);
            ST_WPULSE: ph_load_val = PH_W'(PWE_CYC - 1);
            default:   ph_load_val = '0;
        endcase
    end

    // pin outputs decoded from the state
    always_comb begin
        sram_ce_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_dq_oe = 1'b0;
        req_ready  = 1'b0;
        unique case (state)
            ST_PWRUP:  ;
            ST_IDLE:   req_ready = 1'b1;
            ST_RD: begin
                sram_ce_n = 1'b0;
                sram_oe_n = 1'b0;
            end
            ST_RREL:   ;
            ST_WSET: begin
                sram_ce_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WPULSE: begin
                sram_ce_n  = 1'b0;
                sram_we_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WHOLD: begin
                sram_ce_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            default:   ;
        endcase
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_PS     = 8000,
    parameter int unsigned T_PWRUP_PS = 100_000_000,
    parameter int          AW         = 17,
    parameter int          DW         = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rd_valid,
    input logic          sram_ce_n,
    input logic          sram_oe_n,
    input logic          sram_we_n,
    input logic [AW-1:0] sram_addr,
    input logic [DW-1:0] sram_dq_out,
    input logic          sram_dq_oe
);

    localparam int unsigned PWRUP_CYC = wait_cycles(T_PWRUP_PS, CLK_PS);

    int unsigned since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since <= 0;
        else if (since < PWRUP_CYC)
            since <= since + 1;
    end

    // R1
    pwrup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since < PWRUP_CYC) |-> (sram_ce_n && !req_ready && !sram_dq_oe));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    rdv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!sram_ce_n && !sram_oe_n && sram_we_n));

    // R5
    we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (sram_dq_oe && !sram_ce_n));

    // R5
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> sram_dq_oe);

    // R6
    oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    // R6
    drv_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R7
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> ($stable(sram_addr) && $stable(sram_dq_out)));

endmodule

bind sram_ctl sram_ctl_chk #(
    .CLK_PS     (CLK_PS),
    .T_PWRUP_PS (T_PWRUP_PS),
    .AW         (AW),
    .DW         (DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .sram_ce_n   (sram_ce_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n),
    .sram_addr   (sram_addr),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
);

// File: tb/test_sram_ctl.sv
`timescale 1ns/1ps
module test_sram_ctl;

    localparam int CLK_PS = 8000;

    function automatic int cyc(int lim_ps);
        int c;
        c = (lim_ps + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    int rd_e, hz_e, pwe_e, pwrup_e;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        sram_ce_n, sram_oe_n, sram_we_n;
    logic [16:0] sram_addr;
    logic [7:0]  sram_dq_out;
    logic        sram_dq_oe;
    logic [7:0]  sram_dq_in = 8'h00;

    sram_ctl i_sram_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .sram_ce_n   (sram_ce_n),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n),
        .sram_addr   (sram_addr),
        .sram_dq_out (sram_dq_out),
        .sram_dq_oe  (sram_dq_oe),
        .sram_dq_in  (sram_dq_in)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // memory model, evaluated at falling edges
    logic [7:0] mem [int];
    logic [7:0] shadow [int];
    int   rd_run = 0;
    logic [16:0] last_addr = '0;
    bit   drv_last = 0;
    bit   prev_we = 1;
    int   contention = 0;
    int   bad_write = 0;

    function automatic logic [7:0] mem_rd(int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(negedge clk) begin
        bit rd_cond;
        rd_cond = rst_n && !sram_ce_n && !sram_oe_n && sram_we_n;
        if (rd_cond)
            rd_run = (sram_addr == last_addr && rd_run > 0) ? rd_run + 1 : 1;
        else
            rd_run = 0;
        last_addr = sram_addr;
        if ((rd_cond || drv_last) && sram_dq_oe)
            contention++;
        drv_last = rd_cond;
        if (rd_cond)
            sram_dq_in = (rd_run >= 2) ? mem_rd(int'(sram_addr)) : 8'hxx;
        else
            sram_dq_in = 8'h00;
        if (rst_n && !prev_we && sram_we_n) begin
            if (!sram_ce_n && sram_dq_oe)
                mem[int'(sram_addr)] = sram_dq_out;
            else
                bad_write++;
        end
        prev_we = sram_we_n;
    end

    task automatic do_op(bit we, logic [16:0] a, logic [7:0] d);
        int lat_v = -1;
        int lat_r = -1;
        int we_low = 0;
        bit pins_ok = 1;
        bit busy_ok = 1;
        logic [7:0] got = 8'h00;
        logic [7:0] exp;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_we    = we;
        req_addr  = a;
        req_wdata = d;
        for (int e = 0; e < 24 && lat_r < 0; e++) begin
            @(negedge clk);
            if (e == 0) begin
                req_valid = 1'b0;
                if (req_ready) busy_ok = 0;
            end
            if (rd_valid && lat_v < 0) begin
                lat_v = e;
                got = rd_data;
            end
            if (!sram_we_n) we_low++;
            if (sram_dq_oe && (sram_addr != a || sram_dq_out != d)) pins_ok = 0;
            if (!sram_ce_n && sram_addr != a) pins_ok = 0;
            if (!we && sram_dq_oe) pins_ok = 0;
            if (req_ready) lat_r = e;
        end
        chk(busy_ok, "R2", "ready low after accept", 0, 0);
        if (we) begin
            shadow[int'(a)] = d;
            chk(lat_r == 2 + pwe_e, "R2", "write occupancy", lat_r, 2 + pwe_e);
            chk(we_low == pwe_e, "R5", "strobe low cycles", we_low, pwe_e);
            chk(pins_ok, "R7", "write address/data on pins", 0, 0);
            chk(lat_v < 0, "R5", "no read pulse on write", lat_v, -1);
        end else begin
            exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
            chk(lat_v == rd_e, "R3", "read data latency", lat_v, rd_e);
            chk(lat_r == rd_e + hz_e, "R4", "read occupancy with release", lat_r, rd_e + hz_e);
            chk(got === exp, "R8", "read data", int'(got), int'(exp));
            chk(pins_ok, "R3", "read address held, no drive", 0, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit idle_ok;
        logic [16:0] pool [8];
        rd_e    = imax(imax(cyc(10000), cyc(10000)), cyc(5000));
        hz_e    = cyc(5000);
        pwe_e   = cyc(7000);
        pwrup_e = cyc(100_000_000);
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!req_ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rd_valid,
            "R1", "pins idle in reset", 0, 0);
        rst_n = 1'b1;
        n = 0;
        idle_ok = 1;
        while (!req_ready && n < pwrup_e + 10) begin
            @(negedge clk);
            n++;
            if (!req_ready && (!sram_ce_n || !sram_we_n || !sram_oe_n || sram_dq_oe)) idle_ok = 0;
        end
        chk(n == pwrup_e, "R1", "power-up edges until ready", n, pwrup_e);
        chk(idle_ok, "R1", "pins idle during power-up", 0, 0);

        // directed corners
        do_op(1'b0, 17'h0_0000, 8'h00);        // unwritten location
        do_op(1'b1, 17'h0_0000, 8'hA5);
        do_op(1'b1, 17'h1_FFFF, 8'h5A);
        do_op(1'b0, 17'h0_0000, 8'h00);        // R8 lowest address
        do_op(1'b0, 17'h1_FFFF, 8'h00);        // R8 highest address
        do_op(1'b1, 17'h1_FFFF, 8'hFF);        // overwrite
        do_op(1'b0, 17'h1_FFFF, 8'h00);
        do_op(1'b0, 17'h1_FFFF, 8'h00);        // back-to-back reads
        do_op(1'b1, 17'h0_AAAA, 8'h3C);        // write right after read

        // random mix over a small pool
        pool[0] = 17'h0_0000; pool[1] = 17'h1_FFFF;
        for (int i = 2; i < 8; i++) pool[i] = 17'($urandom);
        for (int i = 0; i < 400; i++) begin
            bit w;
            logic [16:0] a;
            w = ($urandom % 2) == 1;
            a = (($urandom % 4) == 0) ? 17'($urandom) : pool[$urandom % 8];
            do_op(w, a, 8'($urandom));
        end

        repeat (4) @(negedge clk);
        chk(contention == 0, "R6", "cycles with both sides driving", contention, 0);
        chk(bad_write == 0, "R5", "strobe release without select/data", bad_write, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule